// File: doc/BRIEF.md
# Low-Power Stop Mode Recovery Controller

This block sequences a small microcontroller core into and out of a low-power stop state. A one-cycle stop request from the CPU, taken while the core is running, moves the block into the stopped state. In that state the CPU and peripheral clock enables are both held low, and the recovery counter is held at zero.

A module interrupt request or a break request wakes the block from stop. It then enters a recovery phase whose length is chosen by a configuration input: a long delay for crystal oscillators, or a short delay for oscillators that start quickly. Only when that delay has fully elapsed are the clock enables raised again. In the same cycle the CPU receives a one-cycle pulse that starts interrupt stacking.

A break that arrives while stopped also sets a sticky status flag. Software clears the flag with a write-one-to-clear strobe. The active-low asynchronous reset overrides everything. All sequential logic runs on a free-running reference clock that stands in for the doubled oscillator clock, because the gated system clocks are off during stop.

Top module: `stop_recovery_ctrl`

## Requirements
- R1: After reset the status output reads run (2'b00), both clock enables are 1, the stacking pulse is 0 and the break-stop flag is 0.
- R2: A stop request sampled in run makes the status read stopped (2'b01) on the next cycle, with both clock enables at 0.
- R3: The block stays stopped, with clocks off, until an interrupt request or a break request is sampled. It then reads recovering (2'b10), and the clock enables stay 0 throughout recovery.
- R4: The recovery phase lasts exactly LONG_CYC (default 4096) reference cycles when the short-recovery input is 0, and SHORT_CYC (default 32) cycles when it is 1. The input is sampled at the wake-up edge.
- R5: In the first cycle after recovery the status reads run, both clock enables are 1, and the stacking pulse is 1 for exactly that one cycle.
- R6: A break request sampled while stopped sets the break-stop flag. A break request in run or in recovery does not set it.
- R7: A clear strobe resets the break-stop flag. When a set and a clear arrive in the same cycle, the set wins.
- R8: Interrupt, break and stop requests arriving during recovery are ignored: the recovery length is unchanged and no restart occurs.
- R9: Asserting the reset during stop or recovery returns the status to run at once, with clocks enabled and the break-stop flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock (doubled oscillator rate) |
| rst_n | input | 1 | Active-low asynchronous reset, highest priority |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| irq_req | input | 1 | Module interrupt request (wake-up) |
| brk_req | input | 1 | Break request (wake-up) |
| short_rec | input | 1 | 1 selects the short recovery delay, 0 the long one |
| brk_flag_clr | input | 1 | Write-one-to-clear strobe for the break-stop flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| stack_start | output | 1 | One-cycle pulse telling the CPU to begin interrupt stacking |
| brk_stop_flag | output | 1 | Sticky break-during-stop status |
| pm_status | output | 2 | 00 run, 01 stopped, 10 recovering |

## Verification
Wake-ups are tried with an interrupt and with a break, each under both settings of the short-recovery input. Measuring the recovery length at the ports shows whether the delay select is applied, and whether it is taken from the wake-up edge. A run with extra interrupt, break and stop pulses injected in the middle of recovery must give the same length as a clean run, which shows that recovery is not restarted. Break pulses in run, simultaneous set and clear strobes, and a reset asserted during recovery show the flag's set conditions, its priority, and the return to run.

// File: rtl/stoprec_pkg.sv
package stoprec_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_STOP = 2'b01,
    PM_REC  = 2'b10
  } pm_state_e;
endpackage

// File: rtl/rec_timer.sv
module rec_timer #(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32,
  localparam int CNT_W = $clog2(LONG_CYC)
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic start,      // wake-up edge: latch the selected limit
  input  logic run,        // high while recovering; low holds the count at zero
  input  logic short_sel,
  output logic done
);
  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= LONG_M1;
    end else if (start) begin
      lim_q <= short_sel ? SHORT_M1 : LONG_M1;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run && (cnt_q == lim_q);
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import stoprec_pkg::*;
(
  input  logic      clk_ref,
  input  logic      rst_n,
  input  logic      stop_req,
  input  logic      wake,
  input  logic      tmr_done,
  output pm_state_e state,
  output logic      tmr_start,
  output logic      tmr_run,
  output logic      stack_start
);
  pm_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      PM_RUN:  if (stop_req) state_d = PM_STOP;
      PM_STOP: if (wake)     state_d = PM_REC;
      PM_REC:  if (tmr_done) state_d = PM_RUN;
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PM_RUN;
      stack_start <= 1'b0;
    end else begin
      state       <= state_d;
      stack_start <= (state == PM_REC) && tmr_done;
    end
  end

  assign tmr_start = (state == PM_STOP) && wake;
  assign tmr_run   = (state == PM_REC);
endmodule

// File: rtl/brk_status.sv
module brk_status (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/stop_recovery_ctrl.sv
module stop_recovery_ctrl
  import stoprec_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       irq_req,
  input  logic       brk_req,
  input  logic       short_rec,
  input  logic       brk_flag_clr,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       stack_start,
  output logic       brk_stop_flag,
  output logic [1:0] pm_status
);
  pm_state_e state;
  logic      tmr_start;
  logic      tmr_run;
  logic      tmr_done;
  logic      wake;

  assign wake = irq_req || brk_req;

  pm_fsm u_fsm (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .wake        (wake),
    .tmr_done    (tmr_done),
    .state       (state),
    .tmr_start   (tmr_start),
    .tmr_run     (tmr_run),
    .stack_start (stack_start)
  );

  rec_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_tmr (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .start     (tmr_start),
    .run       (tmr_run),
    .short_sel (short_rec),
    .done      (tmr_done)
  );

  brk_status u_brk (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .set_i   ((state == PM_STOP) && brk_req),
    .clr_i   (brk_flag_clr),
    .flag_o  (brk_stop_flag)
  );

  assign cpu_clk_en = (state == PM_RUN);
  assign per_clk_en = (state == PM_RUN);
  assign pm_status  = state;
endmodule

// File: rtl/stoprec_chk.sv
module stoprec_chk #(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32
) (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       stop_req,
  input logic       irq_req,
  input logic       brk_req,
  input logic       short_rec,
  input logic       brk_flag_clr,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       stack_start,
  input logic       brk_stop_flag,
  input logic [1:0] pm_status
);
  localparam int W = $clog2(LONG_CYC) + 2;
  logic [W-1:0] rec_len;
  logic [W-1:0] exp_len;

  // Measures the recovery window with a counter instead of a deep $past.
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rec_len <= '0;
      exp_len <= W'(LONG_CYC);
    end else begin
      rec_len <= (pm_status == 2'b10) ? rec_len + 1'b1 : '0;
      if (pm_status == 2'b01 && (irq_req || brk_req))
        exp_len <= short_rec ? W'(SHORT_CYC) : W'(LONG_CYC);
    end
  end

  p_clk_off_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pm_status != 2'b00) |-> (!cpu_clk_en && !per_clk_en));

  p_stop_entry_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pm_status == 2'b00 && stop_req) |=> (pm_status == 2'b01));

  p_rec_len_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pm_status == 2'b10 && rec_len == exp_len - 1'b1) |=> (pm_status == 2'b00));

  p_no_early_exit_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pm_status == 2'b10 && rec_len < exp_len - 1'b1) |=> (pm_status == 2'b10));

  p_stack_pulse_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    stack_start |=> !stack_start);

  p_stack_after_rec_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    stack_start |-> (pm_status == 2'b00 && $past(pm_status) == 2'b10));

  p_flag_set_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pm_status == 2'b01 && brk_req) |=> brk_stop_flag);

  p_flag_hold_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!brk_flag_clr && brk_stop_flag) |=> brk_stop_flag);
endmodule

bind stop_recovery_ctrl stoprec_chk #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
  .brk_req(brk_req), .short_rec(short_rec), .brk_flag_clr(brk_flag_clr),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .stack_start(stack_start),
  .brk_stop_flag(brk_stop_flag), .pm_status(pm_status)
);

// File: tb/tb_stop_recovery_ctrl.sv
module tb_stop_recovery_ctrl;
  localparam int LONG_CYC  = 4096;
  localparam int SHORT_CYC = 32;

  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, irq_req = 0, brk_req = 0, short_rec = 0, brk_flag_clr = 0;
  logic cpu_clk_en, per_clk_en, stack_start, brk_stop_flag;
  logic [1:0] pm_status;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int exp_q[$];

  always #5 clk_ref = ~clk_ref;

  stop_recovery_ctrl #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
    .brk_req(brk_req), .short_rec(short_rec), .brk_flag_clr(brk_flag_clr),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .stack_start(stack_start),
    .brk_stop_flag(brk_stop_flag), .pm_status(pm_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: measures each recovery at the ports and compares with the queue.
  logic [1:0] prev_st = 2'b00;
  int rec_cnt = 0;
  always @(negedge clk_ref) begin
    if (!rst_n) begin
      prev_st = 2'b00;
      rec_cnt = 0;
    end else begin
      if (pm_status == 2'b10) rec_cnt++;
      if (prev_st == 2'b10 && pm_status == 2'b00) begin
        if (exp_q.size() == 0) chk("R4 unexpected recovery end", 1, 0);
        else chk("R4 recovery length", rec_cnt, exp_q.pop_front());
        chk("R5 stacking pulse", stack_start, 1);
        chk("R5 clock enables", cpu_clk_en && per_clk_en, 1);
        rec_cnt = 0;
      end else if (prev_st == 2'b00 && pm_status == 2'b00) begin
        if (stack_start) chk("R5 stacking pulse width", 1, 0);
      end
      prev_st = pm_status;
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk_ref); sig = 1;
    @(negedge clk_ref); sig = 0;
  endtask

  task automatic enter_stop();
    pulse(stop_req);
    chk("R2 status stopped", pm_status, 1);
    chk("R2 clocks off", cpu_clk_en || per_clk_en, 0);
  endtask

  task automatic wait_run();
    for (int i = 0; i < LONG_CYC + 20 && pm_status != 2'b00; i++) @(negedge clk_ref);
    @(negedge clk_ref);
  endtask

  // Driver: one stop/wake cycle, expected length pushed to the scoreboard.
  task automatic stop_wake(input bit sh, input bit use_brk, input bit noise);
    enter_stop();
    repeat (3) @(negedge clk_ref);
    chk("R3 still stopped", pm_status, 1);
    short_rec = sh;
    exp_q.push_back(sh ? SHORT_CYC : LONG_CYC);
    if (use_brk) pulse(brk_req); else pulse(irq_req);
    short_rec = !sh;  // later changes must not alter the length (R4)
    chk("R3 recovering", pm_status, 2);
    chk("R3 clocks off in recovery", cpu_clk_en || per_clk_en, 0);
    if (noise) begin
      repeat (5) @(negedge clk_ref);
      pulse(irq_req); pulse(brk_req); pulse(stop_req);
      chk("R8 flag untouched by break in recovery", brk_stop_flag, 0);
    end
    wait_run();
    short_rec = 0;
  endtask

  initial begin
    #(200000 * 10);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_ref);
    chk("R1 status run", pm_status, 0);
    chk("R1 clocks on", cpu_clk_en && per_clk_en, 1);
    chk("R1 stack low", stack_start, 0);
    chk("R1 flag low", brk_stop_flag, 0);
    rst_n = 1;
    @(negedge clk_ref);

    stop_wake(1, 0, 0);
    chk("R6 irq wake leaves flag", brk_stop_flag, 0);
    stop_wake(0, 0, 0);
    stop_wake(1, 1, 0);
    chk("R6 break in stop sets flag", brk_stop_flag, 1);
    pulse(brk_flag_clr);
    chk("R7 clear strobe", brk_stop_flag, 0);
    pulse(brk_req);
    chk("R6 break in run ignored", brk_stop_flag, 0);
    chk("R6 break in run stays run", pm_status, 0);
    stop_wake(1, 0, 1);
    stop_wake(0, 0, 1);

    // R7: simultaneous set and clear
    enter_stop();
    @(negedge clk_ref); brk_req = 1; brk_flag_clr = 1;
    @(negedge clk_ref); brk_req = 0; brk_flag_clr = 0;
    exp_q.push_back(LONG_CYC);
    chk("R7 set wins over clear", brk_stop_flag, 1);
    wait_run();

    // R9: reset in the middle of recovery
    enter_stop();
    short_rec = 0;
    pulse(irq_req);
    repeat (100) @(negedge clk_ref);
    rst_n = 0;
    #1;
    chk("R9 run at once", pm_status, 0);
    chk("R9 clocks on", cpu_clk_en && per_clk_en, 1);
    chk("R9 flag cleared", brk_stop_flag, 0);
    @(negedge clk_ref); rst_n = 1;
    repeat (3) @(negedge clk_ref);
    chk("R9 stays run", pm_status, 0);
    stop_wake(1, 0, 0);
    chk("R4 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule